// File: doc/BRIEF.md
# Periodic Compare Interrupt Timer

This block keeps two independent time bases and four compare channels. Each time base has a prescaling up-counter and a 32-bit free-running counter. The up-counter counts timer clocks up to a programmable terminal value, then advances the free-running counter by one. A prescale value of zero gives the longest period, one advance every 2^32 clocks. Software starts and stops each time base on its own.

Each compare channel watches the free-running counter of the time base its select bit names. When that counter steps onto the channel's compare value, the channel latches a sticky flag. It also adds its step value to its compare register, so the next event falls that many counter steps later with no software reload. A channel's interrupt line is high while its flag and its enable are both set. Software sets enables through one register and clears them through another. It clears flags by writing ones.

A single-cycle write port and a combinational read port give access to all state. Word addresses: 0 run bits, 1 source select, 2 flags, 3 enable set, 4 enable clear. Time base b sits at 8+4b (+0 prescale counter, +1 free-running counter, +2 prescale compare). Compare channel u sits at 16+2u (+0 compare value, +1 step).

Top module: `cmp_tick_timer`

## Requirements
- R1: With prescale compare value N not zero and the time base running, the free-running counter advances by one once every N+1 clocks. The prescale counter runs 0..N and returns to 0 on the clock that advances the free-running counter.
- R2: With prescale compare value 0, the prescale counter passes through every value up to 0xFFFFFFFF and only then advances the free-running counter, giving division by 2^32.
- R3: The free-running counter wraps from 0xFFFFFFFF to 0.
- R4: Bit 0 of the run register (address 0) runs time base 0 and bit 1 runs time base 1. A stopped time base holds both its counters.
- R5: Bit u of the source register (address 1) selects time base 0 (value 0) or time base 1 (value 1) for channel u. A channel matches only when the counter of its selected time base advances onto the channel's compare value.
- R6: On every match, the channel's compare register becomes compare plus step, modulo 2^32. With prescale 1 and step 1, a match occurs every two clocks.
- R7: Flag u is bit u of address 2. It is set by a match and stays set through further matches. Writing 1 clears it and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R8: Writing 1 to bit u at address 3 enables channel u. Writing 1 to bit u at address 4 disables it. Both addresses read back the enable bits.
- R9: irq[u] is high exactly while flag u and enable u are both set.
- R10: Writes to a time base's counters and prescale compare are ignored while that time base runs. Writes to a channel's compare and step are ignored while its selected time base runs. While stopped, writes are accepted.
- R11: After reset, every register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one register write per clock |
| addr | input | ADDR_W (5) | Word address for reads and writes |
| wdata | input | CNT_W (32) | Write data |
| rdata | output | CNT_W (32) | Read data for addr, combinational |
| irq | output | NUM_CMP (4) | Per-channel interrupt lines |

## Verification
A wrong prescale count or terminal value shows as a free-running count that is off by the end of the first period. It can be read back the moment the time base is stopped. A compare register that advances by the wrong amount shows as a later flag that never rises or rises early. This can take one full step interval to appear, so the tests keep steps small and read the compare register back directly. A flag or enable fault reaches irq in the same cycle, because the interrupt lines are a plain combination of the two registers.

// File: rtl/ctt_pkg.sv
`timescale 1ns/1ps
package ctt_pkg;
  localparam int unsigned NUM_BLK    = 2;
  localparam int unsigned A_RUN      = 0;
  localparam int unsigned A_SRC      = 1;
  localparam int unsigned A_FLAG     = 2;
  localparam int unsigned A_ENSET    = 3;
  localparam int unsigned A_ENCLR    = 4;
  localparam int unsigned BLK_BASE   = 8;
  localparam int unsigned BLK_STRIDE = 4;
  localparam int unsigned OFS_PRE    = 0;
  localparam int unsigned OFS_FRC    = 1;
  localparam int unsigned OFS_PCMP   = 2;
  localparam int unsigned CMP_BASE   = 16;
  localparam int unsigned CMP_STRIDE = 2;
  localparam int unsigned OFS_COMP   = 0;
  localparam int unsigned OFS_STEP   = 1;

  function automatic int unsigned blk_reg(int unsigned b, int unsigned ofs);
    return BLK_BASE + BLK_STRIDE * b + ofs;
  endfunction

  function automatic int unsigned cmp_reg(int unsigned u, int unsigned ofs);
    return CMP_BASE + CMP_STRIDE * u + ofs;
  endfunction
endpackage

// File: rtl/ctt_cntblk.sv
`timescale 1ns/1ps
// One time base: prescaling up-counter feeding a free-running counter.
module ctt_cntblk #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_pre,
  input  logic             wr_frc,
  input  logic             wr_pcmp,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] pre_cnt,
  output logic [CNT_W-1:0] frc,
  output logic [CNT_W-1:0] pcmp,
  output logic             tick
);
  logic [CNT_W-1:0] pre_q, pre_d, frc_q, frc_d, pcmp_q, pcmp_d;
  logic [CNT_W-1:0] term;

  // zero prescale value means the full counter range
  assign term = (pcmp_q == '0) ? '1 : pcmp_q;
  assign tick = run && (pre_q == term);

  always_comb begin
    pre_d  = pre_q;
    frc_d  = frc_q;
    pcmp_d = pcmp_q;
    if (run) begin
      if (tick) begin
        pre_d = '0;
        frc_d = frc_q + CNT_W'(1);
      end else begin
        pre_d = pre_q + CNT_W'(1);
      end
    end else begin
      if (wr_pre)  pre_d  = wdata;
      if (wr_frc)  frc_d  = wdata;
      if (wr_pcmp) pcmp_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      frc_q  <= '0;
      pcmp_q <= '0;
    end else begin
      pre_q  <= pre_d;
      frc_q  <= frc_d;
      pcmp_q <= pcmp_d;
    end
  end

  assign pre_cnt = pre_q;
  assign frc     = frc_q;
  assign pcmp    = pcmp_q;
endmodule

// File: rtl/ctt_cmpunit.sv
`timescale 1ns/1ps
// One compare channel with self-advancing compare value.
module ctt_cmpunit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] src_frc,
  input  logic             src_tick,
  input  logic             src_run,
  input  logic             wr_comp,
  input  logic             wr_step,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] comp,
  output logic [CNT_W-1:0] step,
  output logic             match
);
  logic [CNT_W-1:0] comp_q, comp_d, step_q, step_d;

  // the counter is about to step onto the compare value
  assign match = src_tick && ((src_frc + CNT_W'(1)) == comp_q);

  always_comb begin
    comp_d = comp_q;
    step_d = step_q;
    if (wr_comp && !src_run)  comp_d = wdata;
    else if (match)           comp_d = comp_q + step_q;
    if (wr_step && !src_run)  step_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
      step_q <= '0;
    end else begin
      comp_q <= comp_d;
      step_q <= step_d;
    end
  end

  assign comp = comp_q;
  assign step = step_q;
endmodule

// File: rtl/ctt_irqctl.sv
`timescale 1ns/1ps
// Sticky flags, enable set/clear and interrupt lines.
module ctt_irqctl #(
  parameter int NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] match,
  input  logic               wr_flag,
  input  logic               wr_enset,
  input  logic               wr_enclr,
  input  logic [NUM_CMP-1:0] wbits,
  output logic [NUM_CMP-1:0] flags,
  output logic [NUM_CMP-1:0] en,
  output logic [NUM_CMP-1:0] irq
);
  logic [NUM_CMP-1:0] flag_q, flag_d, en_q, en_d, clr_mask;

  assign clr_mask = wr_flag ? wbits : '0;

  always_comb begin
    flag_d = (flag_q & ~clr_mask) | match;  // a new match beats a clear
    en_d   = en_q;
    if (wr_enset) en_d = en_q | wbits;
    if (wr_enclr) en_d = en_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flags = flag_q;
  assign en    = en_q;
  assign irq   = flag_q & en_q;
endmodule

// File: rtl/cmp_tick_timer.sv
`timescale 1ns/1ps
module cmp_tick_timer
  import ctt_pkg::*;
#(
  parameter  int CNT_W   = 32,
  parameter  int NUM_CMP = 4,
  localparam int ADDR_W  = $clog2(CMP_BASE + CMP_STRIDE * NUM_CMP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic [NUM_CMP-1:0] irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [NUM_BLK-1:0] run_q, run_d;
  logic [NUM_CMP-1:0] src_q, src_d;
  logic               wr_run, wr_src, wr_flag, wr_enset, wr_enclr;

  assign wr_run   = wr_en && (addr == ADDR_W'(A_RUN));
  assign wr_src   = wr_en && (addr == ADDR_W'(A_SRC));
  assign wr_flag  = wr_en && (addr == ADDR_W'(A_FLAG));
  assign wr_enset = wr_en && (addr == ADDR_W'(A_ENSET));
  assign wr_enclr = wr_en && (addr == ADDR_W'(A_ENCLR));

  always_comb begin
    run_d = run_q;
    src_d = src_q;
    if (wr_run) run_d = wdata[NUM_BLK-1:0];
    if (wr_src) src_d = wdata[NUM_CMP-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      src_q <= '0;
    end else begin
      run_q <= run_d;
      src_q <= src_d;
    end
  end

  logic [NUM_BLK-1:0][CNT_W-1:0] pre_all, frc_all, pcmp_all;
  logic [NUM_BLK-1:0]            tick_all;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    ctt_cntblk #(.CNT_W(CNT_W)) u_blk (
      .clk     (clk),
      .rst_n   (rst_ni),
      .run     (run_q[b]),
      .wr_pre  (wr_en && (addr == ADDR_W'(blk_reg(b, OFS_PRE)))),
      .wr_frc  (wr_en && (addr == ADDR_W'(blk_reg(b, OFS_FRC)))),
      .wr_pcmp (wr_en && (addr == ADDR_W'(blk_reg(b, OFS_PCMP)))),
      .wdata   (wdata),
      .pre_cnt (pre_all[b]),
      .frc     (frc_all[b]),
      .pcmp    (pcmp_all[b]),
      .tick    (tick_all[b])
    );
  end

  logic [NUM_CMP-1:0][CNT_W-1:0] comp_all, step_all;
  logic [NUM_CMP-1:0]            match_v;

  for (genvar u = 0; u < NUM_CMP; u++) begin : g_cmp
    ctt_cmpunit #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_ni),
      .src_frc  (frc_all[src_q[u]]),
      .src_tick (tick_all[src_q[u]]),
      .src_run  (run_q[src_q[u]]),
      .wr_comp  (wr_en && (addr == ADDR_W'(cmp_reg(u, OFS_COMP)))),
      .wr_step  (wr_en && (addr == ADDR_W'(cmp_reg(u, OFS_STEP)))),
      .wdata    (wdata),
      .comp     (comp_all[u]),
      .step     (step_all[u]),
      .match    (match_v[u])
    );
  end

  logic [NUM_CMP-1:0] flags, en;

  ctt_irqctl #(.NUM_CMP(NUM_CMP)) u_irq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .match    (match_v),
    .wr_flag  (wr_flag),
    .wr_enset (wr_enset),
    .wr_enclr (wr_enclr),
    .wbits    (wdata[NUM_CMP-1:0]),
    .flags    (flags),
    .en       (en),
    .irq      (irq)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_RUN))   rdata[NUM_BLK-1:0] = run_q;
    if (addr == ADDR_W'(A_SRC))   rdata[NUM_CMP-1:0] = src_q;
    if (addr == ADDR_W'(A_FLAG))  rdata[NUM_CMP-1:0] = flags;
    if (addr == ADDR_W'(A_ENSET) || addr == ADDR_W'(A_ENCLR))
      rdata[NUM_CMP-1:0] = en;
    for (int unsigned b = 0; b < NUM_BLK; b++) begin
      if (addr == ADDR_W'(blk_reg(b, OFS_PRE)))  rdata = pre_all[b];
      if (addr == ADDR_W'(blk_reg(b, OFS_FRC)))  rdata = frc_all[b];
      if (addr == ADDR_W'(blk_reg(b, OFS_PCMP))) rdata = pcmp_all[b];
    end
    for (int unsigned u = 0; u < NUM_CMP; u++) begin
      if (addr == ADDR_W'(cmp_reg(u, OFS_COMP))) rdata = comp_all[u];
      if (addr == ADDR_W'(cmp_reg(u, OFS_STEP))) rdata = step_all[u];
    end
  end
endmodule

// File: rtl/ctt_checker.sv
`timescale 1ns/1ps
module ctt_checker
  import ctt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [NUM_BLK-1:0]            run,
  input logic [NUM_BLK-1:0][CNT_W-1:0] pre_all,
  input logic [NUM_BLK-1:0][CNT_W-1:0] frc_all,
  input logic [NUM_CMP-1:0]            match,
  input logic [NUM_CMP-1:0]            flags,
  input logic [NUM_CMP-1:0][CNT_W-1:0] comp_all,
  input logic [NUM_CMP-1:0][CNT_W-1:0] step_all
);
  logic flag_wr;
  assign flag_wr = wr_en && (addr == ADDR_W'(A_FLAG));

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic blk_wr;
    assign blk_wr = wr_en && (32'(addr) >= blk_reg(b, OFS_PRE))
                          && (32'(addr) <= blk_reg(b, OFS_PCMP));

    // R1: a running counter moves by at most one per clock
    a_r1_frc_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      run[b] |=> (frc_all[b] == $past(frc_all[b]) ||
                  frc_all[b] == $past(frc_all[b]) + CNT_W'(1)));

    // R4: a stopped, unwritten time base holds its counters
    a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[b] && !blk_wr) |=> ($stable(frc_all[b]) && $stable(pre_all[b])));
  end

  for (genvar u = 0; u < NUM_CMP; u++) begin : g_cmp
    // R7: a match leaves the flag set
    a_r7_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      match[u] |=> flags[u]);

    // R7: only a flag write can drop a flag
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[u] && !flag_wr) |=> flags[u]);

    // R6: a match advances the compare value by the step
    a_r6_comp_advance: assert property (@(posedge clk) disable iff (!rst_n)
      match[u] |=> (comp_all[u] == $past(comp_all[u]) + $past(step_all[u])));
  end
endmodule

bind cmp_tick_timer ctt_checker #(
  .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .wr_en    (wr_en),
  .addr     (addr),
  .run      (run_q),
  .pre_all  (pre_all),
  .frc_all  (frc_all),
  .match    (match_v),
  .flags    (flags),
  .comp_all (comp_all),
  .step_all (step_all)
);

// File: tb/tb_cmp_tick_timer.sv
`timescale 1ns/1ps
module tb_cmp_tick_timer;
  localparam logic [4:0] RUN = 5'd0, SRC = 5'd1, FLAG = 5'd2, ENS = 5'd3, ENC = 5'd4;
  localparam logic [4:0] PRE0 = 5'd8,  FRC0 = 5'd9,  PCM0 = 5'd10;
  localparam logic [4:0] PRE1 = 5'd12, FRC1 = 5'd13, PCM1 = 5'd14;
  localparam logic [4:0] CMP0 = 5'd16, STP0 = 5'd17, CMP1 = 5'd18, STP1 = 5'd19;
  localparam logic [4:0] CMP2 = 5'd20, STP2 = 5'd21;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmp_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // every task starts and ends just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // start the given run bits, let the counters see s active edges, stop all
  task automatic run_for(input logic [31:0] bits, input int s);
    wr(RUN, bits);
    idle(s - 1);
    wr(RUN, 32'd0);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R11 run", RUN, 0);
    chk_reg("R11 flags", FLAG, 0);
    chk_reg("R11 enables", ENS, 0);
    chk_reg("R11 frc0", FRC0, 0);
    chk_reg("R11 comp0", CMP0, 0);
    chk("R11 irq", {28'd0, irq}, 0);
  endtask

  task automatic t_prescale();
    wr(PCM0, 2);                 // divide by 3
    run_for(1, 10);              // 10 active edges
    chk_reg("R1 frc0 after 10 clocks", FRC0, 3);
    chk_reg("R1 prescale count", PRE0, 1);
    chk_reg("R4 idle block1 frc", FRC1, 0);
    idle(3);
    chk_reg("R4 stopped frc0 holds", FRC0, 3);
  endtask

  task automatic t_div32();
    wr(PCM0, 0);
    wr(PRE0, 32'hFFFF_FFFD);
    wr(FRC0, 5);
    run_for(1, 2);
    chk_reg("R2 prescale reaches top", PRE0, 32'hFFFF_FFFF);
    chk_reg("R2 no advance before top", FRC0, 5);
    run_for(1, 1);
    chk_reg("R2 advance after full range", FRC0, 6);
    chk_reg("R2 prescale back to zero", PRE0, 0);
  endtask

  task automatic t_wrap();
    wr(SRC, 0);
    wr(PCM0, 1);
    wr(PRE0, 0);
    wr(FRC0, 32'hFFFF_FFFF);
    wr(CMP0, 0);
    wr(STP0, 4);
    run_for(1, 2);
    chk_reg("R3 counter wraps to zero", FRC0, 0);
    chk_reg("R5 all channels on block0 match at zero", FLAG, 32'hF);
    chk_reg("R6 comp0 advanced by step", CMP0, 4);
    chk_reg("R6 zero step keeps comp1", CMP1, 0);
  endtask

  task automatic t_periodic();
    wr(FLAG, 32'hF);
    chk_reg("R7 write ones clears all", FLAG, 0);
    wr(FRC0, 0);
    wr(CMP0, 1);
    wr(STP0, 1);
    run_for(1, 1);
    chk_reg("R6 no match before advance", FLAG, 0);
    run_for(1, 1);
    chk_reg("R6 first match flag", FLAG, 1);
    chk_reg("R6 comp after first match", CMP0, 2);
    run_for(1, 6);
    chk_reg("R1 frc0 after 8 clocks", FRC0, 4);
    chk_reg("R6 one match per two clocks", CMP0, 5);
  endtask

  task automatic t_source();
    logic [31:0] v;
    wr(FLAG, 32'hF);
    wr(SRC, 32'h2);              // channel 1 on block1
    wr(PCM1, 1);
    wr(FRC1, 0);
    wr(FRC0, 0);
    wr(CMP1, 3);
    wr(STP1, 10);
    run_for(1, 8);
    chk_reg("R5 block0 ran", FRC0, 4);
    rd(FLAG, v);
    chk("R5 channel1 ignores block0", v[1], 0);
    chk_reg("R5 comp1 unchanged", CMP1, 3);
    run_for(2, 6);
    chk_reg("R4 block1 ran alone", FRC1, 3);
    chk_reg("R4 block0 held", FRC0, 4);
    rd(FLAG, v);
    chk("R5 channel1 matches on block1", v[1], 1);
    chk_reg("R6 comp1 advanced", CMP1, 13);
  endtask

  task automatic t_flags_irq();
    wr(FLAG, 32'hF);
    wr(FRC0, 0);
    wr(PRE0, 0);
    wr(CMP2, 1);
    wr(STP2, 100);
    run_for(1, 2);
    chk_reg("R7 channel2 flag", FLAG, 4);
    chk("R9 no irq while disabled", {28'd0, irq}, 0);
    wr(ENS, 4);
    chk("R9 irq follows enable", {28'd0, irq}, 4);
    chk_reg("R8 enable reads back", ENS, 4);
    wr(FLAG, 0);
    chk_reg("R7 writing zero keeps flag", FLAG, 4);
    wr(ENC, 4);
    chk("R8 clear register disables", {28'd0, irq}, 0);
    chk_reg("R8 clear reads back", ENC, 0);
    chk_reg("R7 flag survives disable", FLAG, 4);
    wr(ENS, 4);
    wr(FLAG, 4);
    chk_reg("R7 write one clears flag", FLAG, 0);
    chk("R9 irq drops with flag", {28'd0, irq}, 0);
  endtask

  task automatic t_locked();
    wr(PCM0, 1);
    wr(PRE0, 0);
    wr(FRC0, 0);
    wr(CMP0, 50);
    wr(RUN, 1);
    wr(FRC0, 32'h1234);
    wr(PCM0, 7);
    wr(CMP0, 32'h55);
    wr(RUN, 0);                  // 4 active edges in all
    chk_reg("R10 frc write ignored while running", FRC0, 2);
    chk_reg("R10 prescale write ignored", PCM0, 1);
    chk_reg("R10 compare write ignored", CMP0, 50);
    wr(FRC0, 32'h1234);
    chk_reg("R10 frc write accepted when stopped", FRC0, 32'h1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_prescale();
    t_div32();
    t_wrap();
    t_periodic();
    t_source();
    t_flags_irq();
    t_locked();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule